// File: doc/BRIEF.md
# Timer Interrupt Controller with Edge Sources

This block gathers the five interrupt causes of a timer peripheral and turns them into five separate request lines. The causes are a counter overflow, a periodic tick, an alarm match, the end of clock synchronisation and the end of register synchronisation. Each cause latches a sticky status bit when its event is seen.

The periodic tick is the rising edge of one bit picked out of a 32-bit counter/prescaler vector by a 5-bit index. The two synchronisation causes are falling edges of their busy flags. A mask decides which status bits reach the request outputs. The mask is set through a write-one enable port and cleared through a write-one disable port. Status bits are cleared through a write-one clear port. Each port is a single-cycle write strobe vector.

Bit order on every 5-bit vector: bit 0 overflow, bit 1 periodic, bit 2 alarm, bit 3 clock-ready, bit 4 ready.

Top module: `timer_irq_ctrl`

## Requirements
- R1: After reset, status_o, mask_o and irq_o are all zero. Bit order on every vector is: 0 overflow, 1 periodic, 2 alarm, 3 clock-ready, 4 ready.
- R2: status_o[0] sets the cycle after cnt_ovf_i is high, or the cycle after alarm_hit_i is high while clr_on_alarm_i is high. alarm_hit_i with clr_on_alarm_i low leaves bit 0 clear.
- R3: status_o[2] sets the cycle after alarm_hit_i is high.
- R4: status_o[1] sets the cycle after cnt_vec_i[per_sel_i] goes from 0 to 1. No event is raised in the first cycle after reset, or in a cycle where per_sel_i differs from its value in the previous cycle.
- R5: status_o[3] sets the cycle after clk_busy_i goes from 1 to 0. A rising edge of clk_busy_i has no effect.
- R6: status_o[4] sets the cycle after sync_busy_i goes from 1 to 0.
- R7: A one in mask_en_i sets that mask bit, and a one in mask_dis_i clears it. Zeros have no effect. If both are one for the same bit, the bit is cleared.
- R8: A status bit stays set until a one is written to the same bit of stat_clr_i. Zero bits of stat_clr_i have no effect.
- R9: If a new event and a status clear hit the same bit in the same cycle, the bit stays set.
- R10: Status bits set whether or not they are masked. irq_o[n] is high exactly when status_o[n] and mask_o[n] are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_ovf_i | input | 1 | Counter overflow pulse |
| alarm_hit_i | input | 1 | Alarm match pulse |
| clr_on_alarm_i | input | 1 | Alarm match also counts as overflow |
| cnt_vec_i | input | 32 | Counter/prescaler bits for the periodic source |
| per_sel_i | input | 5 | Index of the periodic bit |
| clk_busy_i | input | 1 | Clock synchronisation busy flag |
| sync_busy_i | input | 1 | Register synchronisation busy flag |
| mask_en_i | input | 5 | Write-one mask set strobes |
| mask_dis_i | input | 5 | Write-one mask clear strobes |
| stat_clr_i | input | 5 | Write-one status clear strobes |
| status_o | output | 5 | Sticky status bits |
| mask_o | output | 5 | Mask bits |
| irq_o | output | 5 | Per-source interrupt requests |

## Verification
The bench aims at the edges that must not fire:
- the selected periodic bit already high when reset is released;
- a switch of per_sel_i onto a bit that is already high;
- a rising busy flag.
A design that misses these raises spurious periodic or ready interrupts.

It also collides a clear with a new event on the same bit. A design that gives the clear priority loses the event. It writes enable and disable together, where the wrong priority leaves a source unmasked.

It sets status bits while their mask is clear and then opens the mask. A design that gates status by mask would show no request at that point.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
    localparam int NUM_SRC   = 5;
    localparam int SRC_OVF   = 0;
    localparam int SRC_PER   = 1;
    localparam int SRC_ALARM = 2;
    localparam int SRC_CLKRD = 3;
    localparam int SRC_READY = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic prev;
        logic primed;
    } edge_state_t;

    typedef struct packed {
        src_vec_t status;
        src_vec_t mask;
    } bank_state_t;
endpackage

// File: rtl/tirq_edge_det.sv
module tirq_edge_det
    import tirq_pkg::*;
#(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic restart_i,
    output logic event_o
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = sig_i;
        st_d.primed = 1'b1;
        if (RISING) begin
            event_o = st_q.primed && !restart_i && sig_i && !st_q.prev;
        end else begin
            event_o = st_q.primed && !restart_i && !sig_i && st_q.prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tirq_per_src.sv
module tirq_per_src #(
    parameter int VEC_W = 32,
    localparam int SEL_W = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] cnt_vec_i,
    input  logic [SEL_W-1:0] per_sel_i,
    output logic             event_o
);
    logic [SEL_W-1:0] sel_d, sel_q;
    logic             tap;
    logic             restart;

    always_comb begin
        sel_d   = per_sel_i;
        tap     = cnt_vec_i[per_sel_i];
        restart = (per_sel_i != sel_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    tirq_edge_det #(.RISING(1'b1)) i_rise (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_i     (tap),
        .restart_i (restart),
        .event_o   (event_o)
    );

    // R4: a selection change never raises a periodic event in that cycle
    assert_no_edge_on_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_sel_i != sel_q) |-> !event_o);
endmodule

// File: rtl/tirq_src_bank.sv
module tirq_src_bank
    import tirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t event_i,
    input  src_vec_t mask_en_i,
    input  src_vec_t mask_dis_i,
    input  src_vec_t stat_clr_i,
    output src_vec_t status_o,
    output src_vec_t mask_o
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            st_d.status[i] = event_i[i] | (st_q.status[i] & ~stat_clr_i[i]);
            st_d.mask[i]   = (st_q.mask[i] | mask_en_i[i]) & ~mask_dis_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;

    // R9: an event always leaves its status bit set, clear or not
    assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i != '0) |=> ((status_o & $past(event_i)) == $past(event_i)));

    // R8: a status bit only falls after a clear strobe on that bit
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status_o & $past(status_o) & ~$past(stat_clr_i)) == '0));

    // R7: the mask holds when neither strobe is written
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_en_i | mask_dis_i) == '0) |=> $stable(mask_o));
endmodule

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl
    import tirq_pkg::*;
#(
    parameter int VEC_W = 32,
    localparam int SEL_W = $clog2(VEC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_ovf_i,
    input  logic               alarm_hit_i,
    input  logic               clr_on_alarm_i,
    input  logic [VEC_W-1:0]   cnt_vec_i,
    input  logic [SEL_W-1:0]   per_sel_i,
    input  logic               clk_busy_i,
    input  logic               sync_busy_i,
    input  logic [NUM_SRC-1:0] mask_en_i,
    input  logic [NUM_SRC-1:0] mask_dis_i,
    input  logic [NUM_SRC-1:0] stat_clr_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] irq_o
);
    src_vec_t events;
    logic     per_ev;
    logic     clkrd_ev;
    logic     ready_ev;

    tirq_per_src #(.VEC_W(VEC_W)) i_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_vec_i (cnt_vec_i),
        .per_sel_i (per_sel_i),
        .event_o   (per_ev)
    );

    tirq_edge_det #(.RISING(1'b0)) i_clkrd (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_i     (clk_busy_i),
        .restart_i (1'b0),
        .event_o   (clkrd_ev)
    );

    tirq_edge_det #(.RISING(1'b0)) i_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_i     (sync_busy_i),
        .restart_i (1'b0),
        .event_o   (ready_ev)
    );

    always_comb begin
        events            = '0;
        events[SRC_OVF]   = cnt_ovf_i | (alarm_hit_i & clr_on_alarm_i);
        events[SRC_PER]   = per_ev;
        events[SRC_ALARM] = alarm_hit_i;
        events[SRC_CLKRD] = clkrd_ev;
        events[SRC_READY] = ready_ev;
    end

    tirq_src_bank i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_i    (events),
        .mask_en_i  (mask_en_i),
        .mask_dis_i (mask_dis_i),
        .stat_clr_i (stat_clr_i),
        .status_o   (status_o),
        .mask_o     (mask_o)
    );

    assign irq_o = status_o & mask_o;

    // R5: a new clock-ready status follows a 1-to-0 busy transition
    assert_clkrd_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[SRC_CLKRD]) |-> ($past(clk_busy_i, 2) && !$past(clk_busy_i)));

    // R6: a new ready status follows a 1-to-0 sync busy transition
    assert_ready_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[SRC_READY]) |-> ($past(sync_busy_i, 2) && !$past(sync_busy_i)));

    // R2: a new overflow status has an overflow or a chained alarm one cycle back
    assert_ovf_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[SRC_OVF]) |-> ($past(cnt_ovf_i) || ($past(alarm_hit_i) && $past(clr_on_alarm_i))));
endmodule

// File: tb/test_timer_irq_ctrl.sv
module test_timer_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_ovf_i = 1'b0;
    logic        alarm_hit_i = 1'b0;
    logic        clr_on_alarm_i = 1'b0;
    logic [31:0] cnt_vec_i = '0;
    logic [4:0]  per_sel_i = '0;
    logic        clk_busy_i = 1'b0;
    logic        sync_busy_i = 1'b0;
    logic [4:0]  mask_en_i = '0;
    logic [4:0]  mask_dis_i = '0;
    logic [4:0]  stat_clr_i = '0;
    logic [4:0]  status_o, mask_o, irq_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_irq_ctrl i_timer_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cnt_ovf_i(cnt_ovf_i), .alarm_hit_i(alarm_hit_i),
        .clr_on_alarm_i(clr_on_alarm_i), .cnt_vec_i(cnt_vec_i), .per_sel_i(per_sel_i),
        .clk_busy_i(clk_busy_i), .sync_busy_i(sync_busy_i), .mask_en_i(mask_en_i),
        .mask_dis_i(mask_dis_i), .stat_clr_i(stat_clr_i), .status_o(status_o),
        .mask_o(mask_o), .irq_o(irq_o)
    );

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic clear_all();
        stat_clr_i = 5'h1f; mask_dis_i = 5'h1f;
        step();
        stat_clr_i = '0; mask_dis_i = '0;
    endtask

    task automatic t_reset();
        check("R1 status after reset", status_o, 5'b0);
        check("R1 mask after reset", mask_o, 5'b0);
        check("R1 irq after reset", irq_o, 5'b0);
        // R4: selected bit 0 was high through reset, no edge
        check("R4 no periodic event after reset", status_o, 5'b0);
    endtask

    task automatic t_overflow_alarm();
        clear_all();
        cnt_ovf_i = 1'b1; step(); cnt_ovf_i = 1'b0;
        check("R2 overflow sets bit0", status_o, 5'b00001);
        clear_all();
        alarm_hit_i = 1'b1; clr_on_alarm_i = 1'b0; step(); alarm_hit_i = 1'b0;
        check("R3 alarm only sets bit2", status_o, 5'b00100);
        clear_all();
        alarm_hit_i = 1'b1; clr_on_alarm_i = 1'b1; step(); alarm_hit_i = 1'b0;
        clr_on_alarm_i = 1'b0;
        check("R2 alarm with clear-on-alarm sets bit0 and bit2", status_o, 5'b00101);
        clear_all();
    endtask

    task automatic t_periodic();
        clear_all();
        cnt_vec_i = 32'h0000_0080; per_sel_i = 5'd3;
        step(2);
        per_sel_i = 5'd7;  // switch onto a bit already high
        step(2);
        check("R4 no event on selection switch", status_o, 5'b0);
        cnt_vec_i[7] = 1'b0; step();
        check("R4 falling tap no event", status_o, 5'b0);
        cnt_vec_i[7] = 1'b1; step();
        check("R4 rising tap sets bit1", status_o, 5'b00010);
        clear_all();
    endtask

    task automatic t_busy();
        clear_all();
        clk_busy_i = 1'b1; step();
        check("R5 rising clock busy no effect", status_o, 5'b0);
        clk_busy_i = 1'b0; step();
        check("R5 clock busy fall sets bit3", status_o, 5'b01000);
        clear_all();
        sync_busy_i = 1'b1; step(2);
        sync_busy_i = 1'b0; step();
        check("R6 sync busy fall sets bit4", status_o, 5'b10000);
        clear_all();
    endtask

    task automatic t_mask();
        clear_all();
        mask_en_i = 5'b10101; step(); mask_en_i = '0;
        check("R7 enable sets mask bits", mask_o, 5'b10101);
        mask_dis_i = 5'b00100; step(); mask_dis_i = '0;
        check("R7 disable clears only bit2", mask_o, 5'b10001);
        mask_en_i = 5'b00010; mask_dis_i = 5'b00010; step();
        mask_en_i = '0; mask_dis_i = '0;
        check("R7 disable wins over enable", mask_o, 5'b10001);
        clear_all();
    endtask

    task automatic t_sticky_and_gate();
        clear_all();
        cnt_ovf_i = 1'b1; alarm_hit_i = 1'b1; step();
        cnt_ovf_i = 1'b0; alarm_hit_i = 1'b0;
        check("R10 status sets while masked", status_o, 5'b00101);
        check("R10 no irq while masked", irq_o, 5'b0);
        step(3);
        check("R8 status sticky", status_o, 5'b00101);
        mask_en_i = 5'b00100; step(); mask_en_i = '0;
        check("R10 irq follows mask", irq_o, 5'b00100);
        stat_clr_i = 5'b00001; step(); stat_clr_i = '0;
        check("R8 clear only bit0", status_o, 5'b00100);
        cnt_ovf_i = 1'b1; stat_clr_i = 5'b00001; step();
        cnt_ovf_i = 1'b0; stat_clr_i = '0;
        check("R9 event beats clear", status_o, 5'b00101);
        stat_clr_i = 5'b00100; step(); stat_clr_i = '0;
        check("R8 irq drops after clear", irq_o, 5'b0);
        clear_all();
    endtask

    initial begin
        cnt_vec_i = 32'h1; per_sel_i = 5'd0;
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_overflow_alarm();
        t_periodic();
        t_busy();
        t_mask();
        t_sticky_and_gate();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule